// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This controller sits next to an in-order fetch stage and runs repeat blocks: short runs of instructions that execute several times with no branch instruction between passes. When decode recognises a repeat instruction it pulses a strobe. The strobe carries the instruction's own address, whether it is the early or the late form, a block-length field and the loop-count sources. From the next cycle the controller watches the stream of issued addresses. Each time the last address of the block issues while passes remain, it tells fetch in that same cycle to go back to the block's first address.

Both the length field and the count hold the wanted amount minus one. A count of zero therefore gives one pass and no jump back. The early form starts its block two slots after the repeat instruction, leaving one spacer. The late form starts four slots after it, leaving three spacers. The late form can take its count from a register. When decode reports that the register source is the reserved top address, the loop never ends until the abort input stops it.

The controller has three states. LP_IDLE has no loop armed. LP_COUNTED runs a loop with a finite pass count. LP_ENDLESS runs a loop with no count. The transitions are:
- IDLE to COUNTED or ENDLESS: a strobe arrives.
- COUNTED or ENDLESS to COUNTED or ENDLESS: a strobe arrives while a loop runs and replaces it.
- COUNTED to IDLE: the final pass's last address issues.
- Any state to IDLE: abort, which takes priority over everything else.

Top module: `hwloop_ctrl`

## Requirements
- R1: The block length is `rep_len_m1 + 1` (field 0 gives a 1-instruction block, field 63 gives 64). The last address is the start plus `rep_len_m1`.
- R2: The block start is `rep_pc + 2` when `rep_late` = 0 (early form) and `rep_pc + 4` when `rep_late` = 1 (late form), modulo 2^ADDR_W. `redirect_pc` always equals this start.
- R3: A count value c gives c+1 passes through the block and exactly c redirects. c = 0 gives a single pass and no redirect.
- R4: Count source:
  - The early form always uses all 14 bits of `rep_imm`.
  - The late form with `rep_use_reg` = 0 uses only `rep_imm[8:0]`.
  - The late form with `rep_use_reg` = 1 uses the 32-bit `rep_reg_val`, under the same minus-one rule.
- R5: The loop is endless only when `rep_late` = 1, `rep_use_reg` = 1 and `rep_endless_sel` = 1. In that case `rep_reg_val` is ignored and a redirect occurs on every pass. In any other combination `rep_endless_sel` has no effect.
- R6: `redirect_valid` is high in the same cycle that the last address issues (`issue_valid` = 1) while passes remain. On the final pass there is no redirect, the next sequential address follows, and `busy` is low from the next cycle.
- R7: A strobe while `busy` = 1 replaces the running loop from the next cycle on.
- R8: While `abort` = 1, `redirect_valid` is 0. `busy` is 0 from the next cycle, and a strobe in the same cycle as `abort` is discarded.
- R9: Out of reset, `busy` and `redirect_valid` are 0.
- R10: A register count of 0xFFFFFFFF is held without truncation, so the loop keeps redirecting for its full length (2^32 passes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rep_valid | input | 1 | Repeat-instruction decode strobe |
| rep_pc | input | ADDR_W | Address of the repeat instruction |
| rep_late | input | 1 | 1 = late form, 0 = early form |
| rep_len_m1 | input | LEN_W | Block length minus one |
| rep_imm | input | EIMM_W | Immediate count (late form uses the low LIMM_W bits) |
| rep_use_reg | input | 1 | Late form takes its count from rep_reg_val |
| rep_reg_val | input | CNT_W | Register count value |
| rep_endless_sel | input | 1 | Register source is the reserved endless address |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_pc | input | ADDR_W | Address of the issuing instruction |
| abort | input | 1 | Cancel any active loop |
| redirect_valid | output | 1 | Fetch must continue at redirect_pc |
| redirect_pc | output | ADDR_W | Block start address |
| busy | output | 1 | A loop is armed |

## Verification
Three pairs of functions can fall in the same cycle. The bench provokes each pair and judges it separately:
- **Abort and last-address issue.** The bench drives abort exactly when the last address of an endless or long counted loop issues. It requires that no redirect appears and that busy is low one cycle later.
- **Abort and strobe.** The bench raises both together and requires the controller to stay idle.
- **Strobe inside a running loop.** The bench issues a fresh strobe in the middle of a loop. It requires that only the new loop's start and pass count govern the following cycles.

A fetch model in the bench closes the loop through redirect_pc and compares the counted passes and redirect targets against values computed from the requirements.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
    typedef enum logic [1:0] {
        LP_IDLE    = 2'd0,
        LP_COUNTED = 2'd1,
        LP_ENDLESS = 2'd2
    } lp_state_e;
endpackage

// File: rtl/hwloop_decode.sv
module hwloop_decode #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 6,
    parameter int CNT_W  = 32,
    parameter int EIMM_W = 14,
    parameter int LIMM_W = 9,
    parameter int EGAP   = 1,
    parameter int LGAP   = 3
) (
    input  logic [ADDR_W-1:0] rep_pc,
    input  logic              rep_late,
    input  logic [LEN_W-1:0]  rep_len_m1,
    input  logic [EIMM_W-1:0] rep_imm,
    input  logic              rep_use_reg,
    input  logic [CNT_W-1:0]  rep_reg_val,
    input  logic              rep_endless_sel,
    output logic [ADDR_W-1:0] blk_start,
    output logic [ADDR_W-1:0] blk_last,
    output logic [CNT_W-1:0]  blk_count,
    output logic              blk_endless
);
    localparam logic [ADDR_W-1:0] EARLY_OFS = ADDR_W'(1 + EGAP);
    localparam logic [ADDR_W-1:0] LATE_OFS  = ADDR_W'(1 + LGAP);

    always_comb begin
        blk_start   = rep_pc + (rep_late ? LATE_OFS : EARLY_OFS);
        blk_last    = blk_start + ADDR_W'(rep_len_m1);
        blk_endless = rep_late & rep_use_reg & rep_endless_sel;
        if (!rep_late)
            blk_count = CNT_W'(rep_imm);
        else if (rep_use_reg)
            blk_count = rep_reg_val;
        else
            blk_count = CNT_W'(rep_imm[LIMM_W-1:0]);
    end
endmodule

// File: rtl/hwloop_iter.sv
module hwloop_iter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last_pass
);
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain_q <= '0;
        else if (load)
            remain_q <= load_val;
        else if (dec && remain_q != '0)
            remain_q <= remain_q - CNT_W'(1);
    end

    assign last_pass = (remain_q == '0);
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 6,
    parameter int CNT_W  = 32,
    parameter int EIMM_W = 14,
    parameter int LIMM_W = 9,
    parameter int EGAP   = 1,
    parameter int LGAP   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rep_valid,
    input  logic [ADDR_W-1:0] rep_pc,
    input  logic              rep_late,
    input  logic [LEN_W-1:0]  rep_len_m1,
    input  logic [EIMM_W-1:0] rep_imm,
    input  logic              rep_use_reg,
    input  logic [CNT_W-1:0]  rep_reg_val,
    input  logic              rep_endless_sel,
    input  logic              issue_valid,
    input  logic [ADDR_W-1:0] issue_pc,
    input  logic              abort,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              busy
);
    lp_state_e         state_q, state_d;
    logic [ADDR_W-1:0] start_q, last_q;
    logic [ADDR_W-1:0] dec_start, dec_last;
    logic [CNT_W-1:0]  dec_count;
    logic              dec_endless;
    logic              accept, last_hit, last_pass, step_back;

    hwloop_decode #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
        .EIMM_W(EIMM_W), .LIMM_W(LIMM_W), .EGAP(EGAP), .LGAP(LGAP)
    ) u_decode (
        .rep_pc          (rep_pc),
        .rep_late        (rep_late),
        .rep_len_m1      (rep_len_m1),
        .rep_imm         (rep_imm),
        .rep_use_reg     (rep_use_reg),
        .rep_reg_val     (rep_reg_val),
        .rep_endless_sel (rep_endless_sel),
        .blk_start       (dec_start),
        .blk_last        (dec_last),
        .blk_count       (dec_count),
        .blk_endless     (dec_endless)
    );

    assign accept   = rep_valid & ~abort;
    assign last_hit = issue_valid & (issue_pc == last_q);

    hwloop_iter #(.CNT_W(CNT_W)) u_iter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_val  (dec_count),
        .dec       (step_back && state_q == LP_COUNTED),
        .last_pass (last_pass)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LP_IDLE;
            start_q <= '0;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                start_q <= dec_start;
                last_q  <= dec_last;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LP_IDLE:    state_d = LP_IDLE;
            LP_COUNTED: if (last_hit && last_pass) state_d = LP_IDLE;
            LP_ENDLESS: state_d = LP_ENDLESS;
            default:    state_d = LP_IDLE;
        endcase
        if (accept)
            state_d = dec_endless ? LP_ENDLESS : LP_COUNTED;
        if (abort)
            state_d = LP_IDLE;
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        step_back = 1'b0;
        unique case (state_q)
            LP_IDLE:    begin busy = 1'b0; step_back = 1'b0; end
            LP_COUNTED: begin busy = 1'b1; step_back = last_hit & ~last_pass & ~abort; end
            LP_ENDLESS: begin busy = 1'b1; step_back = last_hit & ~abort; end
            default:    begin busy = 1'b0; step_back = 1'b0; end
        endcase
        redirect_valid = step_back;
        redirect_pc    = start_q;
    end
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rep_valid,
    input logic              issue_valid,
    input logic              abort,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic              busy
);
    a_r8_abort_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

    a_r8_abort_blocks_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !redirect_valid);

    a_r6_redirect_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (busy && issue_valid));

    a_r7_strobe_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && !abort) |=> busy);

    a_r6_busy_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(abort) || $past(issue_valid)));

    a_r2_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(rep_valid) && $past(busy)) |-> $stable(redirect_pc));

    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !redirect_valid));
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rep_valid      (rep_valid),
    .issue_valid    (issue_valid),
    .abort          (abort),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .busy           (busy)
);

// File: tb/hwloop_ctrl_tb.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rep_valid = 1'b0;
    logic [15:0] rep_pc = '0;
    logic        rep_late = 1'b0;
    logic [5:0]  rep_len_m1 = '0;
    logic [13:0] rep_imm = '0;
    logic        rep_use_reg = 1'b0;
    logic [31:0] rep_reg_val = '0;
    logic        rep_endless_sel = 1'b0;
    logic        issue_valid = 1'b0;
    logic [15:0] issue_pc = '0;
    logic        abort = 1'b0;
    logic        redirect_valid;
    logic [15:0] redirect_pc;
    logic        busy;

    always #2.5 clk = ~clk;

    hwloop_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rep_valid(rep_valid), .rep_pc(rep_pc),
        .rep_late(rep_late), .rep_len_m1(rep_len_m1), .rep_imm(rep_imm),
        .rep_use_reg(rep_use_reg), .rep_reg_val(rep_reg_val),
        .rep_endless_sel(rep_endless_sel), .issue_valid(issue_valid),
        .issue_pc(issue_pc), .abort(abort), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .busy(busy)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [15:0] pc = 16'h0040;
    logic        rd_v;
    logic [15:0] rd_pc;
    logic        bsy;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint exp_count(bit late, bit use_reg, logic [13:0] imm, logic [31:0] rv);
        if (!late) return longint'(imm);
        if (use_reg) return longint'(rv);
        return longint'(imm[8:0]);
    endfunction

    task automatic step(bit strobe, bit ab);
        @(negedge clk);
        issue_valid = 1'b1;
        issue_pc    = pc;
        rep_valid   = strobe;
        rep_pc      = pc;
        abort       = ab;
        #1;
        rd_v  = redirect_valid;
        rd_pc = redirect_pc;
        bsy   = busy;
    endtask

    task automatic setup(bit late, logic [5:0] len, logic [13:0] imm, bit use_reg,
                         logic [31:0] rv, bit esel);
        rep_late = late; rep_len_m1 = len; rep_imm = imm;
        rep_use_reg = use_reg; rep_reg_val = rv; rep_endless_sel = esel;
    endtask

    // Finite loop run to its natural end
    task automatic run_loop(string req, bit late, logic [5:0] len, logic [13:0] imm,
                            bit use_reg, logic [31:0] rv, bit esel);
        longint      ec = exp_count(late, use_reg, imm, rv);
        longint      reds = 0, ends = 0;
        int          guard = 0;
        bit          bad_busy = 0, bad_tgt = 0, stray = 0;
        logic [15:0] s, e;
        setup(late, len, imm, use_reg, rv, esel);
        s = pc + (late ? 16'd4 : 16'd2);
        e = s + 16'(len);
        step(1'b1, 1'b0);
        chk(!rd_v, req, "no redirect on strobe cycle", rd_v, 0);
        pc = pc + 16'd1;
        while (guard < 150000) begin
            guard++;
            step(1'b0, 1'b0);
            if (!bsy) bad_busy = 1;
            if (rd_v && pc != e) stray = 1;
            if (pc == e) begin
                ends++;
                if (rd_v) begin
                    reds++;
                    if (rd_pc != s) bad_tgt = 1;
                    pc = rd_pc;
                end else begin
                    pc = pc + 16'd1;
                    break;
                end
            end else pc = pc + 16'd1;
        end
        chk(!bad_busy, req, "R6 busy held while looping", bad_busy, 0);
        chk(!stray, req, "R6 redirect only at last address", stray, 0);
        chk(!bad_tgt, req, "R2 redirect target", rd_pc, s);
        chk(reds == ec, req, "R3 redirect count", reds, ec);
        chk(ends == ec + 1, req, "R1 passes over last address", ends, ec + 1);
        step(1'b0, 1'b0);
        chk(!bsy, req, "R6 busy low after final pass", bsy, 0);
        chk(!rd_v, req, "R6 no redirect after final pass", rd_v, 0);
        pc = pc + 16'd1;
    endtask

    // Loop stopped by abort on the last address of pass number `passes`
    task automatic run_abort(string req, bit late, logic [5:0] len, bit use_reg,
                             logic [31:0] rv, bit esel, int passes);
        int          ends = 0, guard = 0;
        bit          missing = 0;
        logic [15:0] s, e;
        setup(late, len, 14'd0, use_reg, rv, esel);
        s = pc + (late ? 16'd4 : 16'd2);
        e = s + 16'(len);
        step(1'b1, 1'b0);
        pc = pc + 16'd1;
        while (guard < 150000) begin
            guard++;
            if (pc == e && ends == passes - 1) begin
                step(1'b0, 1'b1);
                chk(!rd_v, "R8", "no redirect while abort", rd_v, 0);
                break;
            end
            step(1'b0, 1'b0);
            if (pc == e) begin
                ends++;
                if (!rd_v || rd_pc != s) missing = 1;
                pc = s;
            end else pc = pc + 16'd1;
        end
        chk(!missing, req, "redirect on every pass before abort", missing, 0);
        chk(ends == passes - 1, req, "passes before abort", ends, passes - 1);
        pc = pc + 16'd1;
        step(1'b0, 1'b0);
        chk(!bsy, "R8", "busy low after abort", bsy, 0);
        pc = pc + 16'd1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        step(1'b0, 1'b0);
        chk(!bsy, "R9", "busy after reset", bsy, 0);
        chk(!rd_v, "R9", "redirect after reset", rd_v, 0);
        pc = pc + 16'd1;

        // R3 count boundaries, R2 both latencies, R1 length boundaries
        run_loop("R3", 1'b0, 6'd0, 14'd0, 1'b0, 32'd0, 1'b0);
        run_loop("R3", 1'b1, 6'd0, 14'd1, 1'b0, 32'd0, 1'b0);
        run_loop("R1", 1'b0, 6'd63, 14'd2, 1'b0, 32'd0, 1'b0);
        run_loop("R2", 1'b1, 6'd63, 14'd1, 1'b0, 32'd0, 1'b0);
        // R4 count sources
        run_loop("R4", 1'b1, 6'd2, 14'h0203, 1'b0, 32'd99, 1'b0);
        run_loop("R4", 1'b1, 6'd1, 14'd40, 1'b1, 32'd5, 1'b0);
        run_loop("R4", 1'b0, 6'd0, 14'd16383, 1'b0, 32'd0, 1'b0);
        // R5 endless selector ignored outside late+register
        run_loop("R5", 1'b0, 6'd1, 14'd2, 1'b1, 32'd7, 1'b1);
        run_loop("R5", 1'b1, 6'd1, 14'd3, 1'b0, 32'd7, 1'b1);
        // R5 endless, register value ignored, stopped by abort
        run_abort("R5", 1'b1, 6'd3, 1'b1, 32'd0, 1'b1, 7);
        // R10 full-range register count does not end early
        run_abort("R10", 1'b1, 6'd1, 1'b1, 32'hFFFF_FFFF, 1'b0, 150);
        // R8 abort and strobe together
        setup(1'b0, 6'd0, 14'd5, 1'b0, 32'd0, 1'b0);
        step(1'b1, 1'b1);
        pc = pc + 16'd1;
        step(1'b0, 1'b0);
        chk(!bsy, "R8", "strobe discarded under abort", bsy, 0);
        pc = pc + 16'd1;
        // R7 replacement mid-loop
        setup(1'b1, 6'd10, 14'd3, 1'b0, 32'd0, 1'b0);
        step(1'b1, 1'b0);
        pc = pc + 16'd1;
        for (int k = 0; k < 5; k++) begin
            step(1'b0, 1'b0);
            pc = pc + 16'd1;
        end
        chk(bsy, "R7", "first loop armed", bsy, 1);
        run_loop("R7", 1'b0, 6'd4, 14'd2, 1'b0, 32'd0, 1'b0);

        // Constrained random finite loops
        for (int n = 0; n < 40; n++) begin
            bit          late = 1'($urandom);
            bit          ur   = 1'($urandom);
            logic [5:0]  len  = 6'($urandom);
            logic [13:0] imm;
            logic [31:0] rv   = 32'($urandom % 16);
            if (late) imm = (14'($urandom) & 14'h3E00) | 14'($urandom % 16);
            else      imm = 14'($urandom % 16);
            pc = 16'h0100 + 16'($urandom % 512);
            run_loop("R4", late, len, imm, ur, rv, late ? 1'b0 : 1'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule